// File: doc/BRIEF.md
# Bit-slip serial-to-parallel converter

This block turns a serial bit stream into 4-bit parallel words. Each clock it takes one bit from one of two serial inputs, picked by a select pin, and shifts it into a register chain. At the end of each frame it copies the collected bits onto registered parallel outputs. The earliest bit of the frame goes to bit 0 of the word. Two frame clocks come out with the data. One runs at one quarter of the input clock and one at one eighth. A serial output repeats the selected stream, delayed by the register chain, so a second converter can be chained behind the first.

A mode pin chooses between two frame lengths. In short mode the word updates every 4 clocks. In long mode it updates every 8 clocks. Long mode serves a two-instance 8-bit arrangement: the downstream converter gets the first half of each 8-bit group from the serial output, and the upstream one keeps the second half. Framing is aligned with an asynchronous sync input. Each rising edge of that input makes the frame counter skip one count, which moves the word boundary one bit later in the stream. A synchronous reset puts the counter back to a known phase.

Top module: `slip_deser`

## Requirements
- R1: In short mode (`long_mode_i` = 0) the word loads on every 4th rising clock edge after reset is released, on edges 4, 8, 12 and so on. A word loaded on edge k holds the bits sampled on edges k-3, k-2, k-1 and k on bits 0, 1, 2 and 3.
- R2: `src_sel_i` = 1 takes the serial bit from `ser_a_i`. `src_sel_i` = 0 takes it from `ser_b_i`. The select is sampled on every clock, together with the bit.
- R3: In long mode (`long_mode_i` = 1) the word loads only on every 8th edge, on edges 8, 16 and so on. It holds the last four bits of that 8-bit group, with the earliest of those four on bit 0.
- R4: `word_o` does not change between loads.
- R5: `div_short_o` is 1 for two counted clocks and 0 for two counted clocks. It rises on the same edge as every short-mode load. `div_long_o` is 1 for four counted clocks and 0 for four. It rises only together with `div_short_o`, on the long-mode load edges.
- R6: `ser_o` equals the selected serial bit sampled 4 edges earlier.
- R7: Each rising edge of `sync_i` holds the frame counter for one edge. If `sync_i` is first high at edge e, the hold falls on edge e+2. That edge does no load, and neither frame clock moves on it. Every later load then comes one edge later than before, so the bit that was on word bit n moves to bit n-1.
- R8: A sync pulse held high for any number of clocks gives exactly one slip. Another slip needs `sync_i` to go low and then high again.
- R9: A `sync_i` pulse that is not high at any rising clock edge does not change the framing.
- R10: While `rst` is high at a clock edge, the block clears the word, the serial output and the counter, and drives both frame clocks to 1. Framing restarts from edge 1 after release.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bit clock |
| rst | input | 1 | Synchronous reset, active high |
| ser_a_i | input | 1 | Serial input A |
| ser_b_i | input | 1 | Serial input B |
| src_sel_i | input | 1 | 1 selects A, 0 selects B |
| long_mode_i | input | 1 | 0 gives a 4-clock frame, 1 gives an 8-clock cascade frame |
| sync_i | input | 1 | Asynchronous frame slip request, one slip per rising edge |
| word_o | output | 4 | Registered parallel word, earliest bit on bit 0 |
| ser_o | output | 1 | Delayed serial stream for a downstream converter |
| div_short_o | output | 1 | Divide-by-4 frame clock |
| div_long_o | output | 1 | Divide-by-8 frame clock |

## Verification
The properties assume that `long_mode_i` changes only while `rst` is high. The long-frame hold check reads the mode from the previous cycle, so a mode change in mid-frame would break that link. The stimulus therefore sets the mode inside the reset task only. The slip properties assume that `sync_i` stays low long enough between pulses for the synchronizer chain to clear. Every sync pulse in the stimulus is at least two clocks high and is followed by at least five clocks low, except one deliberate glitch. That glitch rises and falls between two clock edges, so the synchronizer never samples it.

// File: rtl/slip_deser_pkg.sv
`timescale 1ns/1ps
package slip_deser_pkg;

    // Frame length selection
    typedef enum logic {
        FRAME_SHORT = 1'b0,
        FRAME_LONG  = 1'b1
    } frame_mode_e;

    // Serial source selection
    typedef enum logic {
        PICK_B = 1'b0,
        PICK_A = 1'b1
    } src_pick_e;

endpackage

// File: rtl/slip_sync_edge.sv
`timescale 1ns/1ps
// Synchronizes an asynchronous level and emits a one-cycle pulse on its rise.
module slip_sync_edge #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic async_i,
    output logic rise_o
);
    localparam int CHAIN_W = STAGES + 1;

    typedef struct packed {
        logic [CHAIN_W-1:0] chain;
    } sync_state_t;

    sync_state_t st_d, st_q;

    always_comb begin
        st_d       = st_q;
        st_d.chain = {st_q.chain[CHAIN_W-2:0], async_i};
    end

    always_ff @(posedge clk) begin
        if (rst) st_q <= '0;
        else     st_q <= st_d;
    end

    // Last synchronizer stage high, edge-history stage still low
    assign rise_o = st_q.chain[STAGES-1] & ~st_q.chain[STAGES];
endmodule

// File: rtl/slip_frame_ctr.sv
`timescale 1ns/1ps
// Frame counter with count swallowing; FRAME_W and CASCADE must be powers of two.
module slip_frame_ctr
    import slip_deser_pkg::*;
#(
    parameter int FRAME_W = 4,
    parameter int CASCADE = 2
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        swallow_i,
    input  frame_mode_e mode_i,
    output logic        load_o,
    output logic        div_short_o,
    output logic        div_long_o
);
    localparam int SPAN  = FRAME_W * CASCADE;
    localparam int CNT_W = $clog2(SPAN);
    localparam int SUB_W = $clog2(FRAME_W);

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic             div_s;
        logic             div_l;
    } ctr_state_t;

    ctr_state_t st_d, st_q;
    logic short_end, long_end, frame_end;

    always_comb begin
        st_d      = st_q;
        short_end = &st_q.cnt[SUB_W-1:0];
        long_end  = &st_q.cnt;
        frame_end = (mode_i == FRAME_LONG) ? long_end : short_end;
        if (!swallow_i) begin
            st_d.cnt = st_q.cnt + 1'b1;
        end
        // Frame clocks are high in the first half of each span
        st_d.div_s = ~st_d.cnt[SUB_W-1];
        st_d.div_l = ~st_d.cnt[CNT_W-1];
        load_o     = frame_end & ~swallow_i;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q.cnt   <= '0;
            st_q.div_s <= 1'b1;
            st_q.div_l <= 1'b1;
        end else begin
            st_q <= st_d;
        end
    end

    assign div_short_o = st_q.div_s;
    assign div_long_o  = st_q.div_l;
endmodule

// File: rtl/slip_shift_path.sv
`timescale 1ns/1ps
// Shift chain (newest bit at the top) and registered parallel word.
module slip_shift_path #(
    parameter int FRAME_W = 4
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               bit_i,
    input  logic               load_i,
    output logic [FRAME_W-1:0] word_o,
    output logic               ser_o
);
    typedef struct packed {
        logic [FRAME_W-1:0] shreg;
        logic [FRAME_W-1:0] word;
    } path_state_t;

    path_state_t st_d, st_q;

    always_comb begin
        st_d       = st_q;
        st_d.shreg = {bit_i, st_q.shreg[FRAME_W-1:1]};
        if (load_i) begin
            st_d.word = st_d.shreg;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) st_q <= '0;
        else     st_q <= st_d;
    end

    assign word_o = st_q.word;
    assign ser_o  = st_q.shreg[0];
endmodule

// File: rtl/slip_deser.sv
`timescale 1ns/1ps
module slip_deser
    import slip_deser_pkg::*;
#(
    parameter int FRAME_W     = 4,
    parameter int CASCADE     = 2,
    parameter int SYNC_STAGES = 2
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               ser_a_i,
    input  logic               ser_b_i,
    input  logic               src_sel_i,
    input  logic               long_mode_i,
    input  logic               sync_i,
    output logic [FRAME_W-1:0] word_o,
    output logic               ser_o,
    output logic               div_short_o,
    output logic               div_long_o
);
    src_pick_e   pick;
    frame_mode_e frame_mode;
    logic        picked_bit;
    logic        slip_pulse;
    logic        frame_load;

    assign pick       = src_pick_e'(src_sel_i);
    assign frame_mode = frame_mode_e'(long_mode_i);
    assign picked_bit = (pick == PICK_A) ? ser_a_i : ser_b_i;

    slip_sync_edge #(
        .STAGES (SYNC_STAGES)
    ) u_sync (
        .clk     (clk),
        .rst     (rst),
        .async_i (sync_i),
        .rise_o  (slip_pulse)
    );

    slip_frame_ctr #(
        .FRAME_W (FRAME_W),
        .CASCADE (CASCADE)
    ) u_ctr (
        .clk         (clk),
        .rst         (rst),
        .swallow_i   (slip_pulse),
        .mode_i      (frame_mode),
        .load_o      (frame_load),
        .div_short_o (div_short_o),
        .div_long_o  (div_long_o)
    );

    slip_shift_path #(
        .FRAME_W (FRAME_W)
    ) u_path (
        .clk    (clk),
        .rst    (rst),
        .bit_i  (picked_bit),
        .load_i (frame_load),
        .word_o (word_o),
        .ser_o  (ser_o)
    );
endmodule

// File: rtl/slip_deser_chk.sv
`timescale 1ns/1ps
module slip_deser_chk #(
    parameter int FRAME_W = 4
) (
    input logic               clk,
    input logic               rst,
    input logic               long_mode_i,
    input logic               picked_bit,
    input logic               slip_pulse,
    input logic [FRAME_W-1:0] word_o,
    input logic               ser_o,
    input logic               div_short_o,
    input logic               div_long_o
);
    logic               armed_q;
    logic [FRAME_W-1:0] hist_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            armed_q <= 1'b0;
            hist_q  <= '0;
        end else begin
            armed_q <= 1'b1;
            hist_q  <= {hist_q[FRAME_W-2:0], picked_bit};
        end
    end

    // R4
    word_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (armed_q && !$rose(div_short_o)) |-> $stable(word_o));

    // R3
    long_frame_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (armed_q && $past(long_mode_i) && !$rose(div_long_o)) |-> $stable(word_o));

    // R5
    div_align_chk: assert property (@(posedge clk) disable iff (rst)
        (armed_q && $rose(div_long_o)) |-> $rose(div_short_o));

    // R6
    ser_delay_chk: assert property (@(posedge clk) disable iff (rst)
        ser_o == hist_q[FRAME_W-1]);

    // R7
    slip_freeze_chk: assert property (@(posedge clk) disable iff (rst)
        slip_pulse |=> ($stable(div_short_o) && $stable(div_long_o) && $stable(word_o)));

    // R8
    single_slip_chk: assert property (@(posedge clk) disable iff (rst)
        slip_pulse |=> !slip_pulse);

    // R10
    reset_state_chk: assert property (@(posedge clk)
        rst |=> (word_o == '0 && !ser_o && div_short_o && div_long_o));
endmodule

bind slip_deser slip_deser_chk #(.FRAME_W(FRAME_W)) u_chk (
    .clk         (clk),
    .rst         (rst),
    .long_mode_i (long_mode_i),
    .picked_bit  (picked_bit),
    .slip_pulse  (slip_pulse),
    .word_o      (word_o),
    .ser_o       (ser_o),
    .div_short_o (div_short_o),
    .div_long_o  (div_long_o)
);

// File: tb/slip_deser_tb.sv
`timescale 1ns/1ps
module slip_deser_tb;
    localparam int FW = 4;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          ser_a = 1'b0, ser_b = 1'b0, sel = 1'b0;
    logic          long_mode = 1'b0, sync = 1'b0;
    logic [FW-1:0] word;
    logic          ser_out, d4, d8;

    int            n_chk = 0, n_fail = 0, ecnt = 0, phase = 0;
    logic          hist [0:1023];
    logic [FW-1:0] last_word = '0;
    logic          sync_lvl = 1'b0, glitch = 1'b0;
    logic [15:0]   lfsr = 16'hACE1;

    // Each entry: {select, 4-bit word with the earliest bit in bit 0}
    localparam logic [FW:0] VEC [8] = '{
        5'b1_0001, 5'b0_0001, 5'b1_1000, 5'b0_1000,
        5'b1_0110, 5'b0_1011, 5'b1_1110, 5'b0_0111
    };

    always #2.5 clk = ~clk;

    slip_deser #(.FRAME_W(FW), .CASCADE(2), .SYNC_STAGES(2)) u_dut (
        .clk         (clk),
        .rst         (rst),
        .ser_a_i     (ser_a),
        .ser_b_i     (ser_b),
        .src_sel_i   (sel),
        .long_mode_i (long_mode),
        .sync_i      (sync),
        .word_o      (word),
        .ser_o       (ser_out),
        .div_short_o (d4),
        .div_long_o  (d8)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h (edge %0d)", req, act, exp, ecnt);
        end
    endtask

    function automatic logic [FW-1:0] exp_word(input int k);
        logic [FW-1:0] r;
        for (int i = 0; i < FW; i++) r[i] = hist[k-FW+1+i];
        return r;
    endfunction

    // Called at a falling edge; drives one bit, waits for the rising edge and the next falling edge
    task automatic tick(input logic b, input logic s);
        sel   = s;
        ser_a = s ? b : ~b;
        ser_b = s ? ~b : b;
        sync  = sync_lvl;
        @(posedge clk);
        ecnt++;
        hist[ecnt] = b;
        if (glitch) begin
            #0.5 sync = 1'b1;
            #1.0 sync = 1'b0;
            glitch = 1'b0;
        end
        @(negedge clk);
    endtask

    task automatic step_lfsr();
        lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
    endtask

    task automatic run(input int n, input int span, input string req);
        for (int i = 0; i < n; i++) begin
            tick(lfsr[0], lfsr[7]);
            step_lfsr();
            if (((ecnt - phase) % span) == 0) last_word = exp_word(ecnt);
            check(req, word, last_word);
            if (ecnt >= FW) check("R6", ser_out, hist[ecnt-FW+1]);
        end
    endtask

    task automatic hold_edge(input string req);
        tick(lfsr[0], lfsr[7]);
        step_lfsr();
        check(req, word, last_word);
        phase++;
    endtask

    task automatic do_reset(input logic lm);
        rst       = 1'b1;
        long_mode = lm;
        sync_lvl  = 1'b0;
        sync      = 1'b0;
        @(posedge clk);
        @(posedge clk);
        @(negedge clk);
        check("R10", word, '0);
        check("R10", {d4, d8, ser_out}, 3'b110);
        rst       = 1'b0;
        ecnt      = 0;
        phase     = 0;
        last_word = '0;
    endtask

    initial begin
        #(5.0 * 150000);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: actual running expected finished");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        // Table walk: ordering, source select, hold, frame clocks, serial delay
        do_reset(1'b0);
        for (int v = 0; v < 8; v++) begin
            for (int i = 0; i < FW; i++) begin
                tick(VEC[v][i], VEC[v][FW]);
                if (i < FW - 1) check("R4", word, last_word);
                if (i == FW - 2) check("R5", d4, 1'b0);
            end
            last_word = VEC[v][FW-1:0];
            check("R1/R2", word, VEC[v][FW-1:0]);
            check("R6", ser_out, VEC[v][0]);
            check("R5", d4, 1'b1);
            check("R5", d8, (v % 2 == 1) ? 1'b1 : 1'b0);
        end

        // Reset after non-zero data, then slips with long held pulses
        do_reset(1'b0);
        run(8, 4, "R1");
        sync_lvl = 1'b1;
        run(2, 4, "R7");
        hold_edge("R7");
        run(6, 4, "R7");
        run(10, 4, "R8");
        sync_lvl = 1'b0;
        run(5, 4, "R8");
        sync_lvl = 1'b1;
        run(2, 4, "R7");
        hold_edge("R7");
        sync_lvl = 1'b0;
        run(12, 4, "R7");

        // Glitch between edges: no slip
        glitch = 1'b1;
        run(1, 4, "R9");
        run(12, 4, "R9");

        // Long frame mode
        do_reset(1'b1);
        run(8, 8, "R3");
        check("R5", {d4, d8}, 2'b11);
        run(4, 8, "R3");
        check("R5", {d4, d8}, 2'b10);
        run(20, 8, "R3");

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule